// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a register of `W` bits (eight by default) that shifts toward the high end, shifts toward the low end, loads all bits at once, or holds. A two-bit mode select chooses the operation. All state changes happen on the rising clock edge. The one exception is the active-low reset, which clears every bit at once, whatever the clock or the mode select is doing.

The parallel side works like a shared bidirectional bus, modelled as three signals: `bus_in` (pin values seen from outside), `bus_out` (register contents) and `bus_oe` (per-pin drive enable).
- The block drives the bus only when both active-low enables are low and the mode is not load.
- Load mode releases the bus so that another agent can place load data on it.
- Clearing the enables tri-states the pins, but the register keeps operating.

The lowest and highest bits are also brought out on their own outputs. These taps are always valid, so several registers can be chained through their serial inputs into a longer word in either direction.

Top module: `usr_shift_reg`

## Requirements
- R1: While `rst_n` is low, every register bit is 0 immediately, without waiting for a clock edge. This holds whatever the mode select, the serial inputs or the clock do.
- R2: With `mode_sel` = 2'b00 (hold), a rising clock edge leaves the register unchanged.
- R3: With `mode_sel` = 2'b01 (shift up), a rising edge loads `ser_in_r` into bit 0 and moves each bit n into bit n+1.
- R4: With `mode_sel` = 2'b10 (shift down), a rising edge loads `ser_in_l` into bit W-1 and moves each bit n into bit n-1.
- R5: With `mode_sel` = 2'b11 (load), a rising edge copies `bus_in[n]` into bit n.
- R6: `bus_oe` is all ones when `oe_a_n` and `oe_b_n` are both 0 and `mode_sel` is not 2'b11; otherwise it is all zeros, in the same cycle the inputs change. So the block never drives the bus during a load.
- R7: `bus_out` always equals the register contents, whatever the enables are.
- R8: `tap_lo` equals bit 0 and `tap_hi` equals bit W-1 at all times, independent of the enables.
- R9: Hold, both shifts, load and reset behave identically for all four combinations of `oe_a_n` and `oe_b_n`.
- R10: Two instances can be chained into one 2W-bit register in both directions. To do so, feed the lower instance's `tap_hi` into the upper instance's `ser_in_r`, and the upper instance's `tap_lo` into the lower instance's `ser_in_l`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| oe_a_n | input | 1 | Bus drive enable A, active low |
| oe_b_n | input | 1 | Bus drive enable B, active low |
| ser_in_r | input | 1 | Serial bit entering bit 0 on shift up |
| ser_in_l | input | 1 | Serial bit entering bit W-1 on shift down |
| bus_in | input | W | Values present on the parallel pins (load data) |
| bus_out | output | W | Value the block places on the parallel pins |
| bus_oe | output | W | Per-pin drive enable for the parallel pins |
| tap_lo | output | 1 | Bit 0, always driven |
| tap_hi | output | 1 | Bit W-1, always driven |

## Verification
On every clock edge the assertions check each mode's effect on the next register value, the drive-enable rule including release of the bus during load, that the end taps follow the end bits, and that the register reads zero while reset is held.

The bench scenarios cover behaviour that spans more than one instance or falls between clock edges:
- the 2W-bit word formed by two chained instances;
- an asynchronous clear arriving in the middle of a clock phase;
- load data captured from the bus in the same cycle that the drivers are released;
- the sweep showing each mode works the same under all four enable combinations.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;

  typedef struct packed {
    logic hold;
    logic shr;
    logic shl;
    logic load;
  } usr_ctl_t;
endpackage

// File: rtl/usr_mode_decode.sv
`timescale 1ns/1ps
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0] mode_sel,
  output usr_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (usr_mode_e'(mode_sel))
      MODE_HOLD: ctl.hold = 1'b1;
      MODE_SHR:  ctl.shr  = 1'b1;
      MODE_SHL:  ctl.shl  = 1'b1;
      MODE_LOAD: ctl.load = 1'b1;
      default:   ctl.hold = 1'b1;
    endcase
  end
endmodule

// File: rtl/usr_bit_cell.sv
`timescale 1ns/1ps
module usr_bit_cell
  import usr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  usr_ctl_t ctl,
  input  logic     from_lower,
  input  logic     from_upper,
  input  logic     pin_d,
  output logic     q
);
  // One storage bit with its next-state select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (ctl.load) q <= pin_d;
    else if (ctl.shr)  q <= from_lower;
    else if (ctl.shl)  q <= from_upper;
  end
endmodule

// File: rtl/usr_bus_drive.sv
`timescale 1ns/1ps
module usr_bus_drive
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  usr_ctl_t     ctl,
  input  logic [W-1:0] q,
  output logic [W-1:0] bus_out,
  output logic [W-1:0] bus_oe
);
  logic drive;
  // Released whenever an enable is high or load mode needs the bus.
  assign drive   = ~oe_a_n & ~oe_b_n & ~ctl.load;
  assign bus_oe  = {W{drive}};
  assign bus_out = q;
endmodule

// File: rtl/usr_shift_reg.sv
`timescale 1ns/1ps
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         ser_in_r,
  input  logic         ser_in_l,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic [W-1:0] bus_oe,
  output logic         tap_lo,
  output logic         tap_hi
);
  localparam int MSB = W - 1;

  usr_ctl_t     ctl;
  logic [W-1:0] q;
  logic [W-1:0] lower_v;
  logic [W-1:0] upper_v;

  usr_mode_decode u_dec (
    .mode_sel (mode_sel),
    .ctl      (ctl)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo_end
      assign lower_v[i] = ser_in_r;
    end else begin : g_lo_mid
      assign lower_v[i] = q[i-1];
    end
    if (i == MSB) begin : g_hi_end
      assign upper_v[i] = ser_in_l;
    end else begin : g_hi_mid
      assign upper_v[i] = q[i+1];
    end
    usr_bit_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .from_lower (lower_v[i]),
      .from_upper (upper_v[i]),
      .pin_d      (bus_in[i]),
      .q          (q[i])
    );
  end

  usr_bus_drive #(.W(W)) u_drv (
    .oe_a_n  (oe_a_n),
    .oe_b_n  (oe_b_n),
    .ctl     (ctl),
    .q       (q),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  assign tap_lo = q[0];
  assign tap_hi = q[MSB];
endmodule

// File: rtl/usr_shift_reg_chk.sv
`timescale 1ns/1ps
module usr_shift_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_sel,
  input logic         oe_a_n,
  input logic         oe_b_n,
  input logic         ser_in_r,
  input logic         ser_in_l,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic [W-1:0] bus_oe,
  input logic         tap_lo,
  input logic         tap_hi
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (bus_out == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> $stable(bus_out));

  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |=> (bus_out == {$past(bus_out[W-2:0]), $past(ser_in_r)}));

  a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |=> (bus_out == {$past(ser_in_l), $past(bus_out[W-1:1])}));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> (bus_out == $past(bus_in)));

  a_r6_release_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11 || oe_a_n || oe_b_n) |-> (bus_oe == '0));

  a_r6_drive_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b11 && !oe_a_n && !oe_b_n) |-> (bus_oe == '1));

  a_r8_taps: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_lo == bus_out[0]) && (tap_hi == bus_out[W-1]));
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .oe_a_n   (oe_a_n),
  .oe_b_n   (oe_b_n),
  .ser_in_r (ser_in_r),
  .ser_in_l (ser_in_l),
  .bus_in   (bus_in),
  .bus_out  (bus_out),
  .bus_oe   (bus_oe),
  .tap_lo   (tap_lo),
  .tap_hi   (tap_hi)
);

// File: tb/sim_usr_shift_reg.sv
`timescale 1ns/1ps
module sim_usr_shift_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [1:0]   mode;
  logic         oe_a_n, oe_b_n, sr, sl;
  logic [W-1:0] pin0, pin1;
  logic [W-1:0] out0, oe0, out1, oe1;
  logic         lo0, hi0, lo1, hi1;

  usr_shift_reg #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_in_r(sr), .ser_in_l(lo1), .bus_in(pin0),
    .bus_out(out0), .bus_oe(oe0), .tap_lo(lo0), .tap_hi(hi0));

  // Upper half of a chained 2W-bit register (R10).
  usr_shift_reg #(.W(W)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_in_r(hi0), .ser_in_l(sl), .bus_in(pin1),
    .bus_out(out1), .bus_oe(oe1), .tap_lo(lo1), .tap_hi(hi1));

  typedef struct {
    logic [W-1:0] q0;
    logic [W-1:0] q1;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] m0, m1;
  int           checks = 0;
  int           errors = 0;
  int           cyc = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_op(input logic [1:0] md, input logic a_n, input logic b_n,
                       input logic s_r, input logic s_l,
                       input logic [W-1:0] p0, input logic [W-1:0] p1);
    logic [W-1:0] n0, n1, exp_oe;
    string        tag;
    @(negedge clk);
    mode = md; oe_a_n = a_n; oe_b_n = b_n; sr = s_r; sl = s_l; pin0 = p0; pin1 = p1;
    #1;
    exp_oe = (!a_n && !b_n && md != 2'b11) ? '1 : '0;
    chk("R6 oe u0", 16'(oe0), 16'(exp_oe));
    chk("R6 oe u1", 16'(oe1), 16'(exp_oe));
    case (md)
      2'b00: begin n0 = m0; n1 = m1; tag = "R2"; end
      2'b01: begin n0 = {m0[W-2:0], s_r}; n1 = {m1[W-2:0], m0[W-1]}; tag = "R3 R10"; end
      2'b10: begin n0 = {m1[0], m0[W-1:1]}; n1 = {s_l, m1[W-1:1]}; tag = "R4 R10"; end
      default: begin n0 = p0; n1 = p1; tag = "R5"; end
    endcase
    if (a_n || b_n) tag = {tag, " R9 R7"};
    m0 = n0; m1 = n1;
    sb.push_back('{q0: n0, q1: n1, tag: tag});
  endtask

  // Monitor: each queued item is the state after the next rising edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " u0"}, 16'(out0), 16'(e.q0));
      chk({e.tag, " u1"}, 16'(out1), 16'(e.q1));
      chk("R8 taps", {12'd0, lo0, hi0, lo1, hi1},
          {12'd0, e.q0[0], e.q0[W-1], e.q1[0], e.q1[W-1]});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1 async clear u0", 16'(out0), 16'd0);
    chk("R1 async clear u1", 16'(out1), 16'd0);
    chk("R8 taps in reset", {14'd0, lo0, hi1}, 16'd0);
    m0 = '0; m1 = '0;
    mode = 2'b11; pin0 = '1; pin1 = '1; sr = 1'b1; sl = 1'b1;
    @(posedge clk); #2;
    chk("R1 overrides clock and mode", 16'(out0), 16'd0);
    @(negedge clk);
    mode = 2'b00;
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
    sr = 1'b0; sl = 1'b0; pin0 = '0; pin1 = '0;
    m0 = '0; m1 = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset state u0", 16'(out0), 16'd0);
    chk("R1 reset state u1", 16'(out1), 16'd0);
    rst_n = 1'b1;

    do_op(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    // Every mode under every enable combination (R9).
    for (int md = 0; md < 4; md++) begin
      for (int en = 0; en < 4; en++) begin
        do_op(2'(md), en[0], en[1], en[0] ^ md[0], ~en[1],
              8'(8'h5A + md * 16 + en), 8'(8'hC3 ^ (md * 4 + en)));
        do_op(2'b01, en[0], en[1], 1'b1, 1'b0, 8'h00, 8'h00);
      end
    end

    // Chained shifting across both instances (R10).
    do_op(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h18);
    for (int k = 0; k < 10; k++) do_op(2'b01, 1'b0, 1'b0, k[0], 1'b0, 8'h00, 8'h00);
    for (int k = 0; k < 10; k++) do_op(2'b10, 1'b1, 1'b0, 1'b0, k[1], 8'h00, 8'h00);

    // Asynchronous clear in the middle of operation (R1).
    do_op(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 8'hF0, 8'h0F);
    do_reset();
    do_op(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
    do_op(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96, 8'h69);
    do_op(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    do_op(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    do_op(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule